// File: doc/BRIEF.md
# Capacitive Sense Capture Counter

This block is the counting core behind a capacitive touch measurement. It holds two narrow up-counters that may act alone or be chained into one wide counter, plus a small counter fed by a relaxation oscillator. A mode field, latched only while the block is disabled, picks one of three measurement schemes.

In charge integration, the chained counter advances on reference ticks while the comparator is high, and a comparator trip records its value. In relaxation scheme A, the low counter measures a fixed window of 256 reference ticks while the high counter counts oscillator edges. The edge count is recorded when the window closes. In relaxation scheme B, the small counter measures a window of 64 oscillator edges while the chained counter counts reference ticks. The tick count is recorded when that window closes.

The reference clock arrives as a single-cycle tick in the system clock domain. The oscillator arrives as an asynchronous level, which is synchronized and edge-detected inside the block. A sticky interrupt flag reports either the capture event or the wrap of the chained counter.

Top module: `cs_capture_counter`

## Requirements
- R1: After reset, `cap_value` is 0 and `irq` is 0.
- R2: While `en` is 0, all counters are held at zero. A new measurement starts from zero only after `en` is cleared and set again.
- R3: `mode_sel` encodes 2'b00 as charge integration, 2'b01 as scheme A and 2'b10 as scheme B; 2'b11 acts as charge integration. In charge integration, the chained counter (high byte above low byte) advances on every cycle where `en`, `comp_in` and `ref_tick` are all 1. A fall of `comp_in` (1 in one cycle, 0 in the next) while enabled copies the counter into `cap_value`.
- R4: With `one_shot` at 0, counting continues after a capture, and later trips record the running total.
- R5: With `one_shot` at 1, the first capture freezes the counters. No later event changes `cap_value` until `en` is cleared.
- R6: With `irq_sel` at 0, a capture sets `irq`. With `irq_sel` at 1, only a wrap of the chained counter from all-ones to zero sets `irq`, and a capture does not.
- R7: `irq` stays set until a cycle with `irq_clr` at 1. A new event in that same cycle wins over the clear.
- R8: In scheme A, the low counter counts `ref_tick` and the high counter counts oscillator rising edges. A tick that arrives while the low counter is 255 records the high counter, zero-extended, in `cap_value`.
- R9: In scheme B, the chained counter counts `ref_tick` and the 6-bit counter counts oscillator rising edges. An edge that arrives while the 6-bit counter is 63 records the chained counter in `cap_value`.
- R10: Each rising edge of `osc_in` is counted exactly once, however long the input stays high.
- R11: `mode_sel` takes effect only while `en` is 0. A change while enabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; 0 clears the counters |
| mode_sel | input | 2 | Measurement scheme select |
| one_shot | input | 1 | Freeze the counters after the first capture |
| irq_sel | input | 1 | Interrupt source: 0 capture, 1 wrap |
| comp_in | input | 1 | Comparator output |
| ref_tick | input | 1 | One-cycle divided reference clock pulse |
| osc_in | input | 1 | Asynchronous relaxation oscillator level |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| cap_value | output | 16 | Last captured count |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A wrong counter state only reaches the ports through a capture. A stray or missed increment shows as an off-by-N value in `cap_value` at the next trip or window close. In the window schemes, that can be up to 256 ticks or 64 edges later. The bench therefore closes each window exactly and checks that `cap_value` is still unchanged one event before the close. A wrong freeze, mode latch or wrap decode shows up as a capture that should not happen, or a missing one, in the cycle right after the triggering edge. The bench sweeps the chained counter through its full wrap to expose the overflow decode.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int CS_LO_W  = 8;
    localparam int CS_HI_W  = 8;
    localparam int CS_OSC_W = 6;

    typedef enum logic [1:0] {
        CS_CHARGE  = 2'b00,
        CS_RELAX_A = 2'b01,
        CS_RELAX_B = 2'b10
    } cs_mode_e;

    typedef struct packed {
        logic inc_lo;
        logic inc_hi;
        logic inc_osc;
        logic trip;
        logic wrap;
        logic narrow;
    } cs_route_t;

    function automatic cs_route_t cs_route(
        input cs_mode_e m,
        input logic     run,
        input logic     ref_tick,
        input logic     comp_in,
        input logic     comp_prev,
        input logic     osc_pulse,
        input logic     lo_tc,
        input logic     hi_tc,
        input logic     osc_tc
    );
        cs_route_t r;
        r = '0;
        case (m)
            CS_RELAX_A: begin
                r.inc_lo = run & ref_tick;
                r.inc_hi = run & osc_pulse;
                r.trip   = run & ref_tick & lo_tc;
                r.narrow = 1'b1;
            end
            CS_RELAX_B: begin
                r.inc_lo  = run & ref_tick;
                r.inc_hi  = run & ref_tick & lo_tc;
                r.inc_osc = run & osc_pulse;
                r.trip    = run & osc_pulse & osc_tc;
                r.wrap    = run & ref_tick & lo_tc & hi_tc;
            end
            default: begin
                r.inc_lo = run & ref_tick & comp_in;
                r.inc_hi = run & ref_tick & comp_in & lo_tc;
                r.trip   = run & comp_prev & ~comp_in;
                r.wrap   = run & ref_tick & comp_in & lo_tc & hi_tc;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cs_osc_edge.sv
module cs_osc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    output logic osc_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], osc_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign osc_pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cs_upcnt.sv
module cs_upcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_tc
);
    always_ff @(posedge clk) begin
        if (clear)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end

    assign at_tc = &value;
endmodule

// File: rtl/cs_capture_irq.sv
module cs_capture_irq #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [CAP_W-1:0] cap_data,
    input  logic             wrap,
    input  logic             irq_sel,
    input  logic             irq_clr,
    output logic [CAP_W-1:0] cap_value,
    output logic             irq
);
    logic set_evt;
    assign set_evt = irq_sel ? wrap : capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_value <= '0;
            irq       <= 1'b0;
        end else begin
            if (capture)
                cap_value <= cap_data;
            if (set_evt)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_capture_counter.sv
module cs_capture_counter
    import cs_pkg::*;
#(
    parameter int LO_W     = CS_LO_W,
    parameter int HI_W     = CS_HI_W,
    parameter int OSC_W    = CS_OSC_W,
    parameter int SYNC_LEN = 2,
    localparam int CAP_W   = LO_W + HI_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode_sel,
    input  logic             one_shot,
    input  logic             irq_sel,
    input  logic             comp_in,
    input  logic             ref_tick,
    input  logic             osc_in,
    input  logic             irq_clr,
    output logic [CAP_W-1:0] cap_value,
    output logic             irq
);
    cs_mode_e         mode_q;
    logic             frozen;
    logic             comp_prev;
    logic             run;
    logic             osc_pulse;
    logic [LO_W-1:0]  lo_v;
    logic [HI_W-1:0]  hi_v;
    logic [OSC_W-1:0] cnt_osc;
    logic             lo_tc, hi_tc, osc_tc;
    logic [CAP_W-1:0] cnt_wide;
    logic [CAP_W-1:0] cap_data;
    cs_route_t        rt;

    // Mode latch, freeze flag and comparator history
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= CS_CHARGE;
            frozen    <= 1'b0;
            comp_prev <= 1'b0;
        end else begin
            if (!en)
                mode_q <= cs_mode_e'(mode_sel);
            if (!en)
                frozen <= 1'b0;
            else if (one_shot && rt.trip)
                frozen <= 1'b1;
            comp_prev <= en & comp_in;
        end
    end

    assign run = en & ~frozen;
    assign rt  = cs_route(mode_q, run, ref_tick, comp_in, comp_prev,
                          osc_pulse, lo_tc, hi_tc, osc_tc);

    cs_osc_edge #(.STAGES(SYNC_LEN)) u_edge (
        .clk(clk), .rst(rst), .osc_in(osc_in), .osc_pulse(osc_pulse)
    );

    cs_upcnt #(.W(LO_W)) u_lo (
        .clk(clk), .clear(rst | ~en), .inc(rt.inc_lo), .value(lo_v), .at_tc(lo_tc)
    );

    cs_upcnt #(.W(HI_W)) u_hi (
        .clk(clk), .clear(rst | ~en), .inc(rt.inc_hi), .value(hi_v), .at_tc(hi_tc)
    );

    cs_upcnt #(.W(OSC_W)) u_osc (
        .clk(clk), .clear(rst | ~en), .inc(rt.inc_osc), .value(cnt_osc), .at_tc(osc_tc)
    );

    assign cnt_wide = {hi_v, lo_v};
    assign cap_data = rt.narrow ? {{LO_W{1'b0}}, hi_v} : cnt_wide;

    cs_capture_irq #(.CAP_W(CAP_W)) u_cap (
        .clk(clk), .rst(rst), .capture(rt.trip), .cap_data(cap_data),
        .wrap(rt.wrap), .irq_sel(irq_sel), .irq_clr(irq_clr),
        .cap_value(cap_value), .irq(irq)
    );
endmodule

// File: rtl/cs_capture_counter_chk.sv
module cs_capture_counter_chk #(
    parameter int CAP_W = 16,
    parameter int OSC_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       mode_q,
    input logic             frozen,
    input logic             irq,
    input logic             irq_clr,
    input logic [CAP_W-1:0] cap_value,
    input logic [CAP_W-1:0] cnt_wide,
    input logic [OSC_W-1:0] cnt_osc
);
    // R2
    en_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_wide == '0 && cnt_osc == '0));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(mode_q));

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && en) |=> ($stable(cap_value) && $stable(cnt_wide)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R3
    cap_only_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_value) |-> $past(en));

    // R9
    osc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != 2'b10) |-> (cnt_osc == '0));
endmodule

bind cs_capture_counter cs_capture_counter_chk #(.CAP_W(CAP_W), .OSC_W(OSC_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .mode_q(mode_q), .frozen(frozen),
    .irq(irq), .irq_clr(irq_clr), .cap_value(cap_value),
    .cnt_wide(cnt_wide), .cnt_osc(cnt_osc)
);

// File: tb/cs_capture_counter_tb.sv
module cs_capture_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        one_shot = 1'b0;
    logic        irq_sel = 1'b0;
    logic        comp_in = 1'b0;
    logic        ref_tick = 1'b0;
    logic        osc_in = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] cap_value;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cs_capture_counter u_dut (
        .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .one_shot(one_shot),
        .irq_sel(irq_sel), .comp_in(comp_in), .ref_tick(ref_tick), .osc_in(osc_in),
        .irq_clr(irq_clr), .cap_value(cap_value), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input logic os, input logic is);
        en = 0; ref_tick = 0; comp_in = 0; osc_in = 0;
        mode_sel = m; one_shot = os; irq_sel = is; irq_clr = 1;
        cycles(1);
        irq_clr = 0;
        cycles(1);
    endtask

    task automatic burst(input int n);
        comp_in = 1; ref_tick = 1;
        cycles(n);
        comp_in = 0; ref_tick = 0;
        cycles(1);
    endtask

    task automatic osc_edge(input int high_len);
        osc_in = 1;
        cycles(high_len);
        osc_in = 0;
        cycles(2);
    endtask

    task automatic t_reset();
        chk("R1 cap after reset", cap_value, 16'h0);
        chk("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_charge_cont();
        setup(2'b00, 0, 0);
        en = 1;
        burst(10);
        chk("R3 charge capture", cap_value, 16'd10);
        chk("R6 irq on capture", irq, 1'b1);
        burst(5);
        chk("R4 continuous running total", cap_value, 16'd15);
    endtask

    task automatic t_one_shot();
        setup(2'b00, 1, 0);
        en = 1;
        burst(10);
        chk("R5 first one-shot capture", cap_value, 16'd10);
        burst(5);
        chk("R5 frozen after capture", cap_value, 16'd10);
        en = 0;
        cycles(2);
        en = 1;
        burst(7);
        chk("R2 restart from zero", cap_value, 16'd7);
    endtask

    task automatic t_wrap_irq();
        setup(2'b00, 0, 1);
        en = 1;
        burst(65535);
        chk("R6 capture at all-ones", cap_value, 16'hFFFF);
        chk("R6 capture ignored as irq source", irq, 1'b0);
        comp_in = 1; ref_tick = 1;
        cycles(1);
        chk("R6 irq on wrap", irq, 1'b1);
        comp_in = 0; ref_tick = 0;
        cycles(3);
        chk("R7 irq sticky", irq, 1'b1);
        en = 0; irq_clr = 1;
        cycles(1);
        irq_clr = 0;
        chk("R7 irq cleared by strobe", irq, 1'b0);
    endtask

    task automatic t_relax_a();
        setup(2'b01, 0, 0);
        en = 1;
        osc_edge(2);
        osc_edge(2);
        osc_edge(10); // R10 long high counts once
        osc_edge(2);
        osc_edge(2);
        cycles(3);
        ref_tick = 1;
        cycles(255);
        chk("R8 no capture before window end", cap_value, 16'h0);
        chk("R8 no irq before window end", irq, 1'b0);
        cycles(1);
        ref_tick = 0;
        chk("R8 R10 oscillator edges captured", cap_value, 16'd5);
        chk("R8 irq at window end", irq, 1'b1);
    endtask

    task automatic t_relax_b();
        setup(2'b10, 0, 0);
        en = 1;
        ref_tick = 1;
        cycles(100);
        ref_tick = 0;
        mode_sel = 2'b00;
        comp_in = 1;
        cycles(1);
        comp_in = 0;
        cycles(1);
        chk("R11 mode change while enabled ignored", cap_value, 16'd5);
        for (int i = 0; i < 63; i++) osc_edge(2);
        cycles(2);
        chk("R9 no capture before 64th edge", cap_value, 16'd5);
        osc_edge(2);
        chk("R9 reference count captured", cap_value, 16'd100);
        chk("R9 irq on capture", irq, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 0;
        cycles(1);
        t_reset();
        t_charge_cont();
        t_one_shot();
        t_wrap_irq();
        t_relax_a();
        t_relax_b();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule